// File: doc/BRIEF.md
# Four-Beat Burst Offset Sequencer

This block produces the low-order word offset for a burst of four transfers. A load captures a two-bit start offset taken from the least significant bits of an externally supplied address. Each later advance moves the offset to the next beat, and after the fourth beat the sequence returns to the start. The higher address bits bypass the block.

A static order input selects one of two beat orders. The incrementing order adds the beat number to the start offset modulo four. The interleaved order XORs the start offset with the beat number. A stall input freezes the whole block for as many cycles as needed. A flag marks the cycle in which the fourth beat of the sequence is presented.

Top module: `burst_seq`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `offset_o` is 0 and `last_o` is 0.
- R2: On a rising edge with `stall_i` low and `load_i` high, the start offset becomes `start_i` and the beat number becomes 0, so `offset_o` equals the loaded `start_i` after that edge.
- R3: With `order_i` = 0 (incrementing), advancing from starts 0, 1, 2, 3 presents 0-1-2-3, 1-2-3-0, 2-3-0-1 and 3-0-1-2 respectively.
- R4: With `order_i` = 1 (interleaved), advancing from starts 0, 1, 2, 3 presents 0-1-2-3, 1-0-3-2, 2-3-0-1 and 3-2-1-0 respectively.
- R5: An advance on the fourth beat returns `offset_o` to the start offset, and further advances repeat the same four-beat pattern without stopping.
- R6: On an edge where `stall_i` is high, `load_i`, `adv_i` and `start_i` have no effect, and `offset_o` and `last_o` keep their values.
- R7: When `load_i` and `adv_i` are both high on an unstalled edge, the load wins: the beat number becomes 0 and `offset_o` equals the new `start_i`.
- R8: `last_o` is 1 exactly while the fourth beat (beat number 3) of the sequence is presented, and 0 on the other three beats.
- R9: On an unstalled edge with `load_i` and `adv_i` both low, `offset_o` and `last_o` keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| stall_i | input | 1 | High freezes all state on the edge |
| load_i | input | 1 | Capture a new start offset and restart the beat count |
| adv_i | input | 1 | Step to the next beat |
| order_i | input | 1 | 0 selects incrementing order, 1 selects interleaved order; held static during a burst |
| start_i | input | OFS_W (2) | Start offset, the low bits of the external address |
| offset_o | output | OFS_W (2) | Offset of the beat currently presented |
| last_o | output | 1 | High on the fourth beat of the sequence |

## Verification
The hardest situation to reach is a stall landing on the fourth beat while a load and an advance are both asserted, since it has to show at once that the wrap, the load priority and the freeze do not disturb each other. The stimulus runs a burst to its last beat, raises the stall with both commands asserted and a different start value, holds it for several cycles, and then releases it so that the load takes effect. Every start value runs through more than four advances in both orders, so the wrap is seen from each starting point and not only from zero.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic {
    ORD_INCR  = 1'b0,
    ORD_XOR   = 1'b1
  } burst_order_e;

  // Offset of beat b in incrementing order, masked to w bits.
  function automatic int unsigned incr_offset(int unsigned s, int unsigned b, int unsigned w);
    int unsigned mask;
    mask = (32'd1 << w) - 32'd1;
    return (s + b) & mask;
  endfunction

  // Offset of beat b in interleaved order, masked to w bits.
  function automatic int unsigned xor_offset(int unsigned s, int unsigned b, int unsigned w);
    int unsigned mask;
    mask = (32'd1 << w) - 32'd1;
    return (s ^ b) & mask;
  endfunction

  // Next beat number with wrap at 2**w.
  function automatic int unsigned next_beat(int unsigned b, int unsigned w);
    int unsigned mask;
    mask = (32'd1 << w) - 32'd1;
    return (b + 32'd1) & mask;
  endfunction

endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_seq_pkg::*;
#(
  parameter int OFS_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall_i,
  input  logic             load_i,
  input  logic             adv_i,
  input  logic [OFS_W-1:0] start_i,
  output logic [OFS_W-1:0] start_q,
  output logic [OFS_W-1:0] cnt_q
);

  logic             do_load;
  logic             do_step;
  logic [OFS_W-1:0] cnt_nxt;

  assign do_load = !stall_i && load_i;
  assign do_step = !stall_i && !load_i && adv_i;
  assign cnt_nxt = OFS_W'(next_beat(32'(cnt_q), OFS_W));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      cnt_q   <= '0;
    end else if (do_load) begin
      start_q <= start_i;
      cnt_q   <= '0;
    end else if (do_step) begin
      cnt_q   <= cnt_nxt;
    end
  end

endmodule

// File: rtl/burst_ofs_map.sv
module burst_ofs_map
  import burst_seq_pkg::*;
#(
  parameter int OFS_W = 2
) (
  input  burst_order_e     order,
  input  logic [OFS_W-1:0] start_q,
  input  logic [OFS_W-1:0] cnt_q,
  output logic [OFS_W-1:0] offset,
  output logic             last
);

  localparam int unsigned LAST_BEAT = (1 << OFS_W) - 1;

  logic [OFS_W-1:0] ofs_incr;
  logic [OFS_W-1:0] ofs_xor;

  assign ofs_incr = OFS_W'(incr_offset(32'(start_q), 32'(cnt_q), OFS_W));
  assign ofs_xor  = OFS_W'(xor_offset(32'(start_q), 32'(cnt_q), OFS_W));

  always_comb begin
    case (order)
      ORD_XOR: offset = ofs_xor;
      default: offset = ofs_incr;
    endcase
  end

  assign last = (32'(cnt_q) == LAST_BEAT);

endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_seq_pkg::*;
#(
  parameter int OFS_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall_i,
  input  logic             load_i,
  input  logic             adv_i,
  input  logic             order_i,
  input  logic [OFS_W-1:0] start_i,
  output logic [OFS_W-1:0] offset_o,
  output logic             last_o
);

  logic [OFS_W-1:0] start_q;
  logic [OFS_W-1:0] cnt_q;
  burst_order_e     order_sel;

  assign order_sel = burst_order_e'(order_i);

  burst_beat_ctr #(.OFS_W(OFS_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .stall_i (stall_i),
    .load_i  (load_i),
    .adv_i   (adv_i),
    .start_i (start_i),
    .start_q (start_q),
    .cnt_q   (cnt_q)
  );

  burst_ofs_map #(.OFS_W(OFS_W)) u_map (
    .order   (order_sel),
    .start_q (start_q),
    .cnt_q   (cnt_q),
    .offset  (offset_o),
    .last    (last_o)
  );

endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
  parameter int OFS_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stall_i,
  input logic             load_i,
  input logic             adv_i,
  input logic             order_i,
  input logic [OFS_W-1:0] start_i,
  input logic [OFS_W-1:0] offset_o,
  input logic             last_o,
  input logic [OFS_W-1:0] start_q,
  input logic [OFS_W-1:0] cnt_q
);

  assert_load_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_i && load_i) |=> (cnt_q == '0 && start_q == $past(start_i)));

  // R7: load beats a simultaneous advance
  assert_load_over_adv_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_i && load_i && adv_i) |=> (cnt_q == '0));

  assert_step_wraps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_i && !load_i && adv_i) |=> (cnt_q == OFS_W'($past(cnt_q) + 1'b1) && $stable(start_q)));

  assert_stall_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |=> ($stable(cnt_q) && $stable(start_q)));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_i && !load_i && !adv_i) |=> ($stable(cnt_q) && $stable(start_q)));

  // R3 / R8: last incrementing beat sits one below the start
  assert_last_incr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && !order_i) |-> (offset_o == OFS_W'(start_q - 1'b1)));

  // R4 / R8: last interleaved beat is the start with every bit flipped
  assert_last_xor_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && order_i) |-> (offset_o == ~start_q));

  assert_first_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) |-> (offset_o == start_q && !last_o));

endmodule

bind burst_seq burst_seq_chk #(.OFS_W(OFS_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .stall_i  (stall_i),
  .load_i   (load_i),
  .adv_i    (adv_i),
  .order_i  (order_i),
  .start_i  (start_i),
  .offset_o (offset_o),
  .last_o   (last_o),
  .start_q  (start_q),
  .cnt_q    (cnt_q)
);

// File: tb/sim_burst_seq.sv
`timescale 1ns/1ps
module sim_burst_seq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stall_i = 1'b0;
  logic       load_i = 1'b0;
  logic       adv_i = 1'b0;
  logic       order_i = 1'b0;
  logic [1:0] start_i = 2'd0;
  logic [1:0] offset_o;
  logic       last_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  // Behavioural model state
  int m_start = 0;
  int m_beat  = 0;

  // Interleaved sequences as listed in R4, row = start, column = beat
  int xor_tab [4][4] = '{'{0,1,2,3}, '{1,0,3,2}, '{2,3,0,1}, '{3,2,1,0}};

  always #5 clk = ~clk;

  burst_seq #(.OFS_W(2)) u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .stall_i  (stall_i),
    .load_i   (load_i),
    .adv_i    (adv_i),
    .order_i  (order_i),
    .start_i  (start_i),
    .offset_o (offset_o),
    .last_o   (last_o)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles, expected under 5000", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  function automatic int exp_offset();
    if (order_i) return xor_tab[m_start][m_beat];
    return (m_start + m_beat) % 4;
  endfunction

  task automatic check(string req, int act, int exp, string what);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (start %0d beat %0d order %0d)",
               req, what, act, exp, m_start, m_beat, order_i);
    end
  endtask

  task automatic compare(string req);
    check(req, int'(offset_o), exp_offset(), "offset");
    check("R8", int'(last_o), (m_beat == 3) ? 1 : 0, "last");
  endtask

  // Drive one cycle, update the model on the edge, compare after it.
  task automatic step(string req, bit st, bit ld, bit ad, int s);
    @(negedge clk);
    stall_i = st;
    load_i  = ld;
    adv_i   = ad;
    start_i = 2'(s);
    @(posedge clk);
    if (!st) begin
      if (ld) begin
        m_start = s;
        m_beat  = 0;
      end else if (ad) begin
        m_beat = m_beat + 1;
        if (m_beat == 4) m_beat = 0;
      end
    end
    #1;
    compare(req);
  endtask

  task automatic run_order(bit ord, string req);
    @(negedge clk);
    order_i = ord;
    for (int s = 0; s < 4; s++) begin
      step("R2", 1'b0, 1'b1, 1'b0, s);
      for (int k = 0; k < 3; k++) step(req, 1'b0, 1'b0, 1'b1, (s + 1) % 4);
      step("R5", 1'b0, 1'b0, 1'b1, 0);
      for (int k = 0; k < 3; k++) step("R5", 1'b0, 1'b0, 1'b1, k);
    end
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    check("R1", int'(offset_o), 0, "offset in reset");
    check("R1", int'(last_o), 0, "last in reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R1", int'(offset_o), 0, "offset after reset");
    check("R1", int'(last_o), 0, "last after reset");

    run_order(1'b0, "R3");
    run_order(1'b1, "R4");

    // R9: idle edges hold mid-burst
    step("R2", 1'b0, 1'b1, 1'b0, 2);
    step("R4", 1'b0, 1'b0, 1'b1, 0);
    for (int k = 0; k < 3; k++) step("R9", 1'b0, 1'b0, 1'b0, k);

    // R6: stall on the fourth beat with load and advance asserted
    step("R4", 1'b0, 1'b0, 1'b1, 0);
    step("R4", 1'b0, 1'b0, 1'b1, 0);
    for (int k = 0; k < 4; k++) step("R6", 1'b1, 1'b1, 1'b1, 1);
    step("R6", 1'b1, 1'b0, 1'b1, 3);
    // R7: released load with advance wins
    step("R7", 1'b0, 1'b1, 1'b1, 1);
    step("R4", 1'b0, 1'b0, 1'b1, 0);

    // R7 in incrementing order, mid-burst
    @(negedge clk);
    order_i = 1'b0;
    step("R2", 1'b0, 1'b1, 1'b0, 3);
    step("R3", 1'b0, 1'b0, 1'b1, 0);
    step("R7", 1'b0, 1'b1, 1'b1, 2);
    step("R3", 1'b0, 1'b0, 1'b1, 0);
    step("R6", 1'b1, 1'b0, 1'b1, 0);
    step("R3", 1'b0, 1'b0, 1'b1, 0);
    step("R5", 1'b0, 1'b0, 1'b1, 0);
    step("R5", 1'b0, 1'b0, 1'b1, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule